// File: doc/BRIEF.md
# Branch Condition Code Evaluator

This block decides whether a conditional branch is taken. It takes a 4-bit condition selector and five processor status flags (carry, overflow, zero, negative and one extra flag called here the "wait flag"). It returns a single bit that is high when the selected condition holds. It sits between the flag register and the branch unit. The branch unit uses the bit to choose between the branch target and the fall-through address.

The sixteen selector values follow a fixed numeric order. Codes 0 to 13 form seven complementary pairs: unsigned tests, signed tests and single-flag tests. Code 14 is an unconditional "always". Code 15 does not mean "never". It returns the extra flag unchanged.

The output stage is selected by a parameter. With `REG_OUT = 1` (the default), the result passes through one flip-flop with a synchronous active-high reset. With `REG_OUT = 0`, the block is purely combinational.

Top module: `ccev_cond_eval`

## Requirements
- R1: With REG_OUT=1, a clock edge taken while `rst` is high drives `cond_true` to 0, whatever the selector and flags are.
- R2: Code 0 is true exactly when `flag_c` is 0. Code 1 is true exactly when `flag_c` is 1.
- R3: Code 2 is true exactly when `flag_z` is 0. Code 3 is true exactly when `flag_z` is 1.
- R4: Code 4 is true exactly when `flag_v` is 0. Code 5 is true exactly when `flag_v` is 1.
- R5: Code 6 is true exactly when `flag_n` is 0. Code 7 is true exactly when `flag_n` is 1.
- R6: Code 8 (unsigned lower-or-same) is true when `flag_c` OR `flag_z` is 1. Code 9 (unsigned higher) is its exact inverse.
- R7: Code 10 (signed greater-or-equal) is true when `flag_v` equals `flag_n`. Code 11 (signed less-than) is true when they differ.
- R8: Code 13 (signed less-or-equal) is true when (`flag_v` XOR `flag_n`) OR `flag_z` is 1. Code 12 (signed greater-than) is its inverse.
- R9: Code 14 is true for every combination of the five flags.
- R10: Code 15 returns `flag_p` unchanged.
- R11: With REG_OUT=1, `cond_true` shows the result for the selector and flags sampled at the previous rising clock edge. A change of the inputs between edges does not reach the output before the next edge.
- R12: A flag that the selected code does not name has no effect on `cond_true`. In particular, `flag_p` affects only code 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the registered output stage |
| rst | input | 1 | Synchronous active-high reset of the output register |
| cond_code | input | 4 | Condition selector, 0 to 15 |
| flag_c | input | 1 | Carry flag |
| flag_v | input | 1 | Overflow flag |
| flag_z | input | 1 | Zero flag |
| flag_n | input | 1 | Negative flag |
| flag_p | input | 1 | Extra flag, tested only by code 15 |
| cond_true | output | 1 | High when the selected condition holds |

## Verification
The hardest property to show from the ports is R12. Proving that an unrelated flag has no effect needs that flag toggled while every other input is held fixed. Spot tests rarely produce such pairs. The stimulus therefore walks all 32 flag combinations under every one of the 16 codes, so for each code every unused flag appears both low and high against each setting of the flags that code does use. The latency rule (R11) is brought out by sampling the output between an input change and the next rising edge.

// File: rtl/ccev_pkg.sv
package ccev_pkg;

  localparam int CODE_W = 4;

  typedef enum logic [CODE_W-1:0] {
    CC_CARRY_CLR  = 4'd0,
    CC_CARRY_SET  = 4'd1,
    CC_ZERO_CLR   = 4'd2,
    CC_ZERO_SET   = 4'd3,
    CC_OVF_CLR    = 4'd4,
    CC_OVF_SET    = 4'd5,
    CC_NEG_CLR    = 4'd6,
    CC_NEG_SET    = 4'd7,
    CC_ULE        = 4'd8,
    CC_UGT        = 4'd9,
    CC_SGE        = 4'd10,
    CC_SLT        = 4'd11,
    CC_SGT        = 4'd12,
    CC_SLE        = 4'd13,
    CC_ALWAYS     = 4'd14,
    CC_WAITFLAG   = 4'd15
  } cond_e;

  typedef struct packed {
    logic p;
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;

endpackage

// File: rtl/ccev_terms.sv
module ccev_terms
  import ccev_pkg::*;
#(
  parameter int NUM_CODES = 16
) (
  input  flags_t               flags,
  output logic [NUM_CODES-1:0] truth
);

  logic signed_mismatch;
  logic unsigned_low_same;
  logic signed_low_same;

  always_comb begin
    signed_mismatch   = flags.v ^ flags.n;
    unsigned_low_same = flags.c | flags.z;
    signed_low_same   = signed_mismatch | flags.z;

    truth               = '0;
    truth[CC_CARRY_CLR] = ~flags.c;
    truth[CC_CARRY_SET] = flags.c;
    truth[CC_ZERO_CLR]  = ~flags.z;
    truth[CC_ZERO_SET]  = flags.z;
    truth[CC_OVF_CLR]   = ~flags.v;
    truth[CC_OVF_SET]   = flags.v;
    truth[CC_NEG_CLR]   = ~flags.n;
    truth[CC_NEG_SET]   = flags.n;
    truth[CC_ULE]       = unsigned_low_same;
    truth[CC_UGT]       = ~(flags.c | flags.z);
    truth[CC_SGE]       = (flags.v == flags.n);
    truth[CC_SLT]       = signed_mismatch;
    truth[CC_SGT]       = ~signed_low_same;
    truth[CC_SLE]       = signed_low_same;
    truth[CC_ALWAYS]    = 1'b1;
    truth[CC_WAITFLAG]  = flags.p;
  end

  always_comb begin
    if (!$isunknown(flags)) begin
      assert_ule_ugt_split_R6: assert (truth[CC_ULE] ^ truth[CC_UGT]);
      assert_sge_slt_split_R7: assert (truth[CC_SGE] ^ truth[CC_SLT]);
      assert_sgt_implies_sge_R8: assert (!truth[CC_SGT] || truth[CC_SGE]);
      assert_zero_forces_sle_R8: assert (!flags.z || truth[CC_SLE]);
    end
  end

endmodule

// File: rtl/ccev_select.sv
module ccev_select
  import ccev_pkg::*;
#(
  parameter int SEL_W     = 4,
  parameter int NUM_CODES = 1 << SEL_W
) (
  input  logic [SEL_W-1:0]     sel,
  input  logic [NUM_CODES-1:0] truth,
  input  logic                 wait_flag,
  output logic                 hit
);

  always_comb begin
    hit = truth[sel];
  end

  always_comb begin
    if (!$isunknown(sel) && !$isunknown(truth)) begin
      if (sel == CC_ALWAYS) begin
        assert_always_true_R9: assert (hit);
      end
      if (sel == CC_WAITFLAG) begin
        assert_waitflag_pass_R10: assert (hit == wait_flag);
      end
    end
  end

endmodule

// File: rtl/ccev_stage.sv
module ccev_stage #(
  parameter bit REG_OUT = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  generate
    if (REG_OUT) begin : g_reg
      logic q_r;

      always_ff @(posedge clk) begin
        if (rst) q_r <= 1'b0;
        else     q_r <= d;
      end

      assign q = q_r;

      assert_reset_clears_R1: assert property (
        @(posedge clk) rst |=> !q
      );

      assert_one_cycle_latency_R11: assert property (
        @(posedge clk) disable iff (rst) 1'b1 |=> (q == $past(d))
      );
    end else begin : g_comb
      assign q = d;
    end
  endgenerate

endmodule

// File: rtl/ccev_cond_eval.sv
module ccev_cond_eval
  import ccev_pkg::*;
#(
  parameter int CODE_WIDTH = 4,
  parameter bit REG_OUT    = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [CODE_WIDTH-1:0] cond_code,
  input  logic                  flag_c,
  input  logic                  flag_v,
  input  logic                  flag_z,
  input  logic                  flag_n,
  input  logic                  flag_p,
  output logic                  cond_true
);

  localparam int NUM_CODES = 1 << CODE_WIDTH;

  flags_t               flags;
  logic [NUM_CODES-1:0] truth;
  logic                 hit;

  always_comb begin
    flags.c = flag_c;
    flags.v = flag_v;
    flags.z = flag_z;
    flags.n = flag_n;
    flags.p = flag_p;
  end

  ccev_terms #(
    .NUM_CODES (NUM_CODES)
  ) terms_i (
    .flags (flags),
    .truth (truth)
  );

  ccev_select #(
    .SEL_W     (CODE_WIDTH),
    .NUM_CODES (NUM_CODES)
  ) select_i (
    .sel       (cond_code),
    .truth     (truth),
    .wait_flag (flag_p),
    .hit       (hit)
  );

  ccev_stage #(
    .REG_OUT (REG_OUT)
  ) stage_i (
    .clk (clk),
    .rst (rst),
    .d   (hit),
    .q   (cond_true)
  );

endmodule

// File: tb/ccev_cond_eval_tb_top.sv
module ccev_cond_eval_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] cond_code = 4'd0;
  logic       flag_c = 1'b0;
  logic       flag_v = 1'b0;
  logic       flag_z = 1'b0;
  logic       flag_n = 1'b0;
  logic       flag_p = 1'b0;
  logic       cond_true;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  ccev_cond_eval #(
    .CODE_WIDTH (4),
    .REG_OUT    (1'b1)
  ) dut_i (
    .clk       (clk),
    .rst       (rst),
    .cond_code (cond_code),
    .flag_c    (flag_c),
    .flag_v    (flag_v),
    .flag_z    (flag_z),
    .flag_n    (flag_n),
    .flag_p    (flag_p),
    .cond_true (cond_true)
  );

  // flags bit order: {p, n, z, v, c}
  function automatic logic model(input int code, input logic [4:0] f);
    logic c, v, z, n, p, base;
    int   pair;
    c = f[0]; v = f[1]; z = f[2]; n = f[3]; p = f[4];
    if (code == 14) return 1'b1;
    if (code == 15) return p;
    pair = code / 2;
    case (pair)
      0: base = c;
      1: base = z;
      2: base = v;
      3: base = n;
      4: base = c | z;
      5: base = v ^ n;
      default: base = (v ^ n) | z;
    endcase
    // pair 4 places the base term at the even code; the others at the odd code
    if (pair == 4) return (code % 2 == 0) ? base : ~base;
    return (code % 2 == 1) ? base : ~base;
  endfunction

  function automatic string req_of(input int code);
    case (code / 2)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      5: return "R7";
      6: return "R8";
      default: return (code == 14) ? "R9" : "R10";
    endcase
  endfunction

  task automatic check(input string req, input logic exp, input string what);
    checks++;
    if (cond_true !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, cond_true, exp);
    end
  endtask

  task automatic drive(input int code, input logic [4:0] f);
    cond_code = code[3:0];
    {flag_p, flag_n, flag_z, flag_v, flag_c} = f;
  endtask

  initial begin
    // R1: reset with an always-true selector
    drive(14, 5'b11111);
    repeat (3) @(posedge clk);
    #1 check("R1", 1'b0, "output during reset");
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #1 check("R9", 1'b1, "always after reset release");

    // R11: input change does not reach output before the next edge
    @(negedge clk);
    drive(1, 5'b00000);
    @(posedge clk); #1 check("R11", 1'b0, "carry-set with C=0 after edge");
    @(negedge clk);
    drive(14, 5'b00000);
    #1 check("R11", 1'b0, "output held before edge");
    @(posedge clk); #1 check("R11", 1'b1, "new result after edge");

    // R2..R10, R12: exhaustive sweep of codes and flag patterns
    for (int code = 0; code < 16; code++) begin
      for (int fl = 0; fl < 32; fl++) begin
        @(negedge clk);
        drive(code, fl[4:0]);
        @(posedge clk); #1;
        check(req_of(code), model(code, fl[4:0]),
              $sformatf("code=%0d flags(pnzvc)=%05b", code, fl[4:0]));
      end
    end

    // R12: toggling P under code 0 leaves the result unchanged
    for (int pv = 0; pv < 2; pv++) begin
      @(negedge clk);
      drive(0, {pv[0], 4'b0000});
      @(posedge clk); #1 check("R12", 1'b1, "P toggled under code 0");
    end

    // R1: mid-run reset clears a true result
    @(negedge clk);
    drive(15, 5'b10000);
    @(posedge clk); #1 check("R10", 1'b1, "code 15 with P=1");
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk); #1 check("R1", 1'b0, "mid-run reset");
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #1 check("R10", 1'b1, "code 15 after reset");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule